// File: doc/BRIEF.md
# Round-Robin Codec Job Scheduler

This block shares one speech codec engine among several channels inside each 10 ms frame. One datapath does both encoding and decoding, and it runs one job at a time. A frame tick samples two ready vectors, one bit per channel for each direction. Every channel that is ready and enabled then holds a pending encode job, a pending decode job, or both. The scheduler hands these jobs to the codec controller one after another. Channels are taken in round-robin order with equal priority. For each job it drives a start pulse together with the channel number and the direction, then waits for the controller's done pulse.

A runtime register holds the number of active channels. Channels at or above that count are never granted, so adding a channel changes only that number and not the logic. The scheduler counts the cycles the engine spends busy in the current frame. If work is still outstanding when the next tick arrives, it raises a deadline-miss flag. It then drops the stale pending jobs and loads the new ones.

The controller has two states. `S_IDLE` means no job is outstanding. `S_BUSY` means one job is running on the engine. The transitions are:
- *launch*: `S_IDLE` to `S_BUSY`, when a grant is made.
- *chain*: `S_BUSY` to `S_BUSY`, when done arrives and the next grant is made at once.
- *retire*: `S_BUSY` to `S_IDLE`, when done arrives and no grant is made.
- *wait*: `S_BUSY` to `S_BUSY`, while done is low.
- *rest*: `S_IDLE` to `S_IDLE`, while nothing is pending.

Top module: `codec_job_sched`

## Requirements
- R1: After reset the block is in `S_IDLE`. `job_start`, `job_busy`, `deadline_miss` and `busy_cycles` are all zero. The active-channel count equals NUM_CH.
- R2: At each `frame_tick`, every earlier pending job is dropped. Channel c then becomes pending for encode if `enc_ready[c]` is 1, and pending for decode if `dec_ready[c]` is 1, but only when c is below the active-channel count.
- R3: Each grant goes to the first channel with any pending job, searching upward from the channel after the last one granted and wrapping from NUM_CH-1 to 0. After reset the search starts at channel 0.
- R4: `job_decode` is 0 for an encode job and 1 for a decode job. When both are pending on the chosen channel, encode is granted first. The decode is granted only when the search reaches that channel again.
- R5: At most one job is outstanding. `job_start` is a one-cycle pulse issued only when no job is running or in the cycle after done. `job_busy` stays high until `job_done` is seen.
- R6: When `job_done` is high in `S_BUSY` and work is pending (and no tick occurs), the next `job_start` appears in the very next cycle.
- R7: No grant is made in a cycle where `frame_tick` is high. If `job_done` and `frame_tick` fall in the same cycle, the job retires and the next grant is taken from the newly loaded pending jobs.
- R8: At each tick, `deadline_miss` is loaded with 1 if any job was still pending or a job was running without done in that cycle, and with 0 otherwise. It holds that value until the next tick.
- R9: `busy_cycles` returns to 0 at each tick. It then counts every cycle spent in `S_BUSY` outside tick cycles, and saturates at 2^CYC_W-1.
- R10: A one-cycle `cfg_load` sets the active-channel count to `cfg_count`, clamped to NUM_CH. Channels at or above the count are never granted, and their pending jobs are dropped.
- R11: `job_done` while in `S_IDLE` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at the start of each frame |
| enc_ready | input | NUM_CH | Per-channel encode frame ready, sampled at the tick |
| dec_ready | input | NUM_CH | Per-channel decode frame ready, sampled at the tick |
| cfg_load | input | 1 | Load strobe for the active-channel count |
| cfg_count | input | $clog2(NUM_CH+1) | New active-channel count |
| job_done | input | 1 | Codec controller finished the current job |
| job_start | output | 1 | One-cycle pulse that launches a job |
| job_ch | output | $clog2(NUM_CH) | Channel of the launched job |
| job_decode | output | 1 | 0 encode, 1 decode |
| job_busy | output | 1 | A job is outstanding |
| busy_cycles | output | CYC_W | Engine busy cycles in the current frame |
| deadline_miss | output | 1 | Previous frame ended with unfinished work |

## Verification
Two events can land in the same cycle: the frame tick and the done pulse of the running job. The bench raises both together in two cases. In one, other channels are still pending, so the flag must be set. In the other, nothing else is pending, so the job finished in time and the flag must stay clear. In both cases the bench checks that no grant appears in the cycle after the tick, that the engine is idle, and that the next grant follows the newly loaded ready pattern. A third case lets the tick arrive while a job is still running without done. There the flag must rise, the job must stay outstanding, and the next grant must follow the later done.

// File: rtl/codec_job_pkg.sv
package codec_job_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } sched_state_t;

endpackage

// File: rtl/cjs_rr_pick.sv
module cjs_rr_pick #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
)(
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   last,
    output logic              found,
    output logic [CH_W-1:0]   sel
);

    int idx;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        idx   = 0;
        for (int k = 1; k <= NUM_CH; k++) begin
            idx = int'(last) + k;
            if (idx >= NUM_CH) begin
                idx = idx - NUM_CH;
            end
            if (!found && req[idx]) begin
                found = 1'b1;
                sel   = CH_W'(idx);
            end
        end
    end

endmodule

// File: rtl/cjs_pend_store.sv
module cjs_pend_store #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_CH-1:0] enc_in,
    input  logic [NUM_CH-1:0] dec_in,
    input  logic [NUM_CH-1:0] keep,
    input  logic              clr,
    input  logic [CH_W-1:0]   clr_ch,
    input  logic              clr_dec,
    output logic [NUM_CH-1:0] enc_q,
    output logic [NUM_CH-1:0] dec_q
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit;
        assign hit = clr && (clr_ch == CH_W'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enc_q[c] <= 1'b0;
                dec_q[c] <= 1'b0;
            end else if (load) begin
                enc_q[c] <= enc_in[c] & keep[c];
                dec_q[c] <= dec_in[c] & keep[c];
            end else if (!keep[c]) begin
                enc_q[c] <= 1'b0;
                dec_q[c] <= 1'b0;
            end else if (hit) begin
                if (clr_dec) begin
                    dec_q[c] <= 1'b0;
                end else begin
                    enc_q[c] <= 1'b0;
                end
            end
        end
    end

    // R2: a tick with nothing ready leaves nothing pending
    a_r2_empty_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enc_in == '0 && dec_in == '0) |=> (enc_q == '0 && dec_q == '0));

endmodule

// File: rtl/cjs_busy_ctr.sv
module cjs_busy_ctr #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> (count == TOP));

    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/codec_job_sched.sv
module codec_job_sched
    import codec_job_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CYC_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CNT_W = $clog2(NUM_CH + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [NUM_CH-1:0] enc_ready,
    input  logic [NUM_CH-1:0] dec_ready,
    input  logic              cfg_load,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              job_done,
    output logic              job_start,
    output logic [CH_W-1:0]   job_ch,
    output logic              job_decode,
    output logic              job_busy,
    output logic [CYC_W-1:0]  busy_cycles,
    output logic              deadline_miss
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_CH);

    sched_state_t      state, state_nxt;
    logic [CNT_W-1:0]  act_q;
    logic [NUM_CH-1:0] ch_mask;
    logic [NUM_CH-1:0] enc_q, dec_q, req;
    logic [CH_W-1:0]   last_q, pick;
    logic              found, grant, grant_dec;

    // active-channel count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= MAX_CNT;
        end else if (cfg_load) begin
            act_q <= (cfg_count > MAX_CNT) ? MAX_CNT : cfg_count;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign ch_mask[c] = (CNT_W'(c) < act_q);
    end

    assign req = (enc_q | dec_q) & ch_mask;

    cjs_pend_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_tick),
        .enc_in  (enc_ready),
        .dec_in  (dec_ready),
        .keep    (ch_mask),
        .clr     (grant),
        .clr_ch  (pick),
        .clr_dec (grant_dec),
        .enc_q   (enc_q),
        .dec_q   (dec_q)
    );

    cjs_rr_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req   (req),
        .last  (last_q),
        .found (found),
        .sel   (pick)
    );

    assign grant_dec = !enc_q[pick];
    assign grant     = !frame_tick && found &&
                       ((state == S_IDLE) || (state == S_BUSY && job_done));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: launch, chain, retire, wait, rest
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (grant) begin
                    state_nxt = S_BUSY;
                end
            end
            S_BUSY: begin
                if (job_done) begin
                    state_nxt = grant ? S_BUSY : S_IDLE;
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_start     <= 1'b0;
            job_ch        <= '0;
            job_decode    <= 1'b0;
            last_q        <= CH_W'(NUM_CH - 1);
            deadline_miss <= 1'b0;
        end else begin
            job_start <= grant;
            if (grant) begin
                job_ch     <= pick;
                job_decode <= grant_dec;
                last_q     <= pick;
            end
            if (frame_tick) begin
                deadline_miss <= (|req) || (state == S_BUSY && !job_done);
            end
        end
    end

    assign job_busy = (state == S_BUSY);

    cjs_busy_ctr #(.W(CYC_W)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_tick),
        .inc   (state == S_BUSY),
        .count (busy_cycles)
    );

    // R5: a launch only when the engine was free or just finished
    a_r5_single_job: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> $past(!job_busy || job_done));

    // R5: outstanding job holds until done
    a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (job_busy && !job_done) |=> job_busy);

    // R6: chained grant right after done
    a_r6_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (job_busy && job_done && !frame_tick && (|req)) |=> job_start);

    // R7: no launch from a tick cycle
    a_r7_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !job_start);

    // R8: leftover work at a tick raises the flag
    a_r8_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && (|req)) |=> deadline_miss);

    // R10: launched channel lies below the active count
    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> (int'(job_ch) < int'($past(act_q))));

endmodule

// File: tb/codec_job_sched_test.sv
module codec_job_sched_test;

    localparam int N   = 4;
    localparam int CW  = 6;
    localparam int SAT = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_tick = 1'b0;
    logic [N-1:0]  enc_ready = '0;
    logic [N-1:0]  dec_ready = '0;
    logic          cfg_load = 1'b0;
    logic [2:0]    cfg_count = '0;
    logic          job_done = 1'b0;
    logic          job_start;
    logic [1:0]    job_ch;
    logic          job_decode;
    logic          job_busy;
    logic [CW-1:0] busy_cycles;
    logic          deadline_miss;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model
    int       m_last = N - 1;
    int       m_act  = N;
    logic [N-1:0] m_ep = '0;
    logic [N-1:0] m_dp = '0;
    int       m_acc  = 0;

    always #4 clk = ~clk;

    codec_job_sched #(.NUM_CH(N), .CYC_W(CW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_tick    (frame_tick),
        .enc_ready     (enc_ready),
        .dec_ready     (dec_ready),
        .cfg_load      (cfg_load),
        .cfg_count     (cfg_count),
        .job_done      (job_done),
        .job_start     (job_start),
        .job_ch        (job_ch),
        .job_decode    (job_decode),
        .job_busy      (job_busy),
        .busy_cycles   (busy_cycles),
        .deadline_miss (deadline_miss)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [N-1:0] amask();
        logic [N-1:0] m;
        for (int c = 0; c < N; c++) m[c] = (c < m_act);
        return m;
    endfunction

    task automatic model_next(output int ch, output logic dec);
        ch = -1;
        dec = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (ch < 0 && (m_ep[c] || m_dp[c])) begin
                ch = c;
                dec = !m_ep[c];
            end
        end
    endtask

    // check the launch visible now against the model and consume it
    task automatic check_grant();
        int ch;
        logic dec;
        model_next(ch, dec);
        chk(job_start === 1'b1, "R6 start", int'(job_start), 1);
        chk(int'(job_ch) == ch, "R3 channel", int'(job_ch), ch);
        chk(job_decode == dec, "R4 direction", int'(job_decode), int'(dec));
        if (dec) m_dp[ch] = 1'b0; else m_ep[ch] = 1'b0;
        m_last = ch;
    endtask

    task automatic set_act(input int n);
        cfg_load = 1'b1;
        cfg_count = 3'(n);
        step();
        cfg_load = 1'b0;
        m_act = (n > N) ? N : n;
        m_ep = m_ep & amask();
        m_dp = m_dp & amask();
    endtask

    task automatic do_tick(input logic [N-1:0] e, input logic [N-1:0] d,
                           input bit with_done, input bit exp_miss);
        frame_tick = 1'b1;
        enc_ready = e;
        dec_ready = d;
        job_done = with_done;
        step();
        frame_tick = 1'b0;
        job_done = 1'b0;
        chk(deadline_miss == exp_miss, "R8 miss flag", int'(deadline_miss), int'(exp_miss));
        chk(busy_cycles == 0, "R9 cleared at tick", int'(busy_cycles), 0);
        chk(job_start == 1'b0, "R7 no grant from tick", int'(job_start), 0);
        m_ep = e & amask();
        m_dp = d & amask();
        m_acc = 0;
    endtask

    task automatic run_jobs(input int lat, input bit lead);
        int ch;
        logic dec;
        if (lead) step();
        forever begin
            model_next(ch, dec);
            if (ch < 0) break;
            check_grant();
            for (int i = 1; i < lat; i++) begin
                step();
                chk(job_busy && !job_start, "R5 one outstanding", int'(job_start), 0);
            end
            job_done = 1'b1;
            step();
            job_done = 1'b0;
            m_acc += lat;
        end
        chk(!job_start && !job_busy, "R5 idle when empty", int'(job_busy), 0);
        chk(int'(busy_cycles) == ((m_acc > SAT) ? SAT : m_acc), "R9 busy count",
            int'(busy_cycles), (m_acc > SAT) ? SAT : m_acc);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(job_start == 0, "R1 start", int'(job_start), 0);
        chk(job_busy == 0, "R1 busy", int'(job_busy), 0);
        chk(deadline_miss == 0, "R1 miss", int'(deadline_miss), 0);
        chk(busy_cycles == 0, "R1 count", int'(busy_cycles), 0);

        // R11: done while idle
        job_done = 1'b1;
        step();
        job_done = 1'b0;
        chk(!job_start && !job_busy, "R11 idle done ignored", int'(job_busy), 0);
        chk(busy_cycles == 0, "R11 count untouched", int'(busy_cycles), 0);

        // R1/R2/R3/R4: exhaustive ready patterns with default count
        for (int v = 0; v < 256; v++) begin
            do_tick(4'(v), 4'(v >> 4), 0, 0);
            run_jobs(1 + (v % 3), 1);
        end

        // R10: every count 0..7 (clamped) against several patterns
        for (int a = 0; a < 8; a++) begin
            set_act(a);
            for (int p = 0; p < 16; p++) begin
                do_tick(4'(p), 4'(~p ^ a), 0, 0);
                run_jobs(1, 1);
            end
        end
        set_act(N);

        // R10: lowering the count mid-frame drops pending jobs
        do_tick(4'b1111, 4'b1111, 0, 0);
        step();
        check_grant();
        set_act(1);
        job_done = 1'b1;
        step();
        job_done = 1'b0;
        m_acc = 2;
        run_jobs(1, 0);
        do_tick(4'b0000, 4'b0000, 0, 0);
        set_act(N);

        // R7/R8: done and tick together with work left
        do_tick(4'b0011, 4'b0000, 0, 0);
        step();
        check_grant();
        do_tick(4'b0100, 4'b1000, 1, 1);
        chk(!job_busy, "R7 retired at tick", int'(job_busy), 0);
        run_jobs(1, 1);

        // R7/R8: done and tick together with nothing left
        do_tick(4'b0001, 4'b0000, 0, 0);
        step();
        check_grant();
        do_tick(4'b0000, 4'b0000, 1, 0);
        chk(!job_busy && !job_start, "R7 idle after joint tick", int'(job_busy), 0);
        step();
        chk(!job_start, "R2 nothing loaded", int'(job_start), 0);

        // R8/R5: tick while a job is still running
        do_tick(4'b0001, 4'b0000, 0, 0);
        step();
        check_grant();
        do_tick(4'b0010, 4'b0000, 0, 1);
        chk(job_busy == 1, "R5 survives tick", int'(job_busy), 1);
        step();
        step();
        chk(job_busy && !job_start, "R5 still one job", int'(job_start), 0);
        job_done = 1'b1;
        step();
        job_done = 1'b0;
        m_acc = 3;
        run_jobs(2, 0);
        do_tick(4'b0000, 4'b0000, 0, 0);

        // R9: saturation
        do_tick(4'b0001, 4'b0000, 0, 0);
        run_jobs(80, 1);
        chk(int'(busy_cycles) == SAT, "R9 saturation", int'(busy_cycles), SAT);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule